// File: doc/BRIEF.md
# Single-Wire Half-Duplex Serial Transmitter

This block is the sending half of an asynchronous serial port that shares a single data wire between both directions. A byte written by software goes into a one-entry holding buffer. From there it moves into a shift register, which serialises it as a framed character. The frame advances only on a baud tick pulse supplied from outside the block. A direction input decides whether the wire is driven. When the direction input is low, the wire is released so the far end can talk. A loop output always gives the local receiver whatever is on the wire: the driven value while sending, and the external pin value otherwise.

Turning the transmitter on sends an all-ones preamble frame first. Software may queue its first byte in the holding buffer while the preamble is still shifting. Once the transmitter is on and quiet, a byte goes straight into the shifter and its frame starts with no preamble. Two flags guide software. The buffer-empty flag says when the next byte may be written. The transmit-complete flag says when the last frame has fully left the wire, so the direction can be turned back to receive.

Top module: `sw_uart_tx`

## Requirements
- R1: `pin_oe_o` follows `dir_tx_i` (1 = drive the wire). `rx_line_o` equals `pin_o` when `dir_tx_i` is 1 and equals `pin_i` when it is 0.
- R2: In the cycle after `tx_en_i` is first sampled high, a preamble of ten all-ones bits is loaded. `pin_o` stays 1 and `tx_done_o` stays 0 until the tenth baud tick after that load.
- R3: A data frame is made of bit 0 = start (0), bits 1..8 = data LSB first, bit 9 = stop (1). The current bit is shown on `pin_o` and advances on each tick. The frame ends on the tenth tick after loading, and the line then idles at 1.
- R4: A byte written while the shifter is busy (and not ending a frame on a tick in that cycle) is held: `buf_empty_o` is 0 from the next cycle. The byte is loaded on the tick that ends the current frame, so its start bit appears in the next cycle and `buf_empty_o` returns to 1.
- R5: When enabled, idle and with an empty buffer, a written byte loads directly. `pin_o` shows the start bit (0) in the next cycle and `buf_empty_o` stays 1.
- R6: `tx_done_o` is 1 exactly when no frame is shifting and the buffer is empty. It drops in the cycle after an accepted write.
- R7: A write while the buffer already holds a byte is dropped. Only the held byte is sent.
- R8: While `tx_en_i` is 0, no frame starts, writes are ignored, `pin_o` is 1 and both flags are 1. Dropping `tx_en_i` abandons the frame in flight and any held byte from the next cycle.
- R9: Without a baud tick, a write or an enable edge, `pin_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One-cycle bit-rate pulse |
| wr_en_i | input | 1 | Byte write strobe |
| wr_data_i | input | DATA_W | Byte to send |
| tx_en_i | input | 1 | Transmitter enable |
| dir_tx_i | input | 1 | 1 = drive wire, 0 = release for receive |
| pin_i | input | 1 | Value seen on the shared wire from outside |
| pin_o | output | 1 | Serial data toward the wire |
| pin_oe_o | output | 1 | Wire drive enable |
| rx_line_o | output | 1 | Wire value looped to the receiver |
| buf_empty_o | output | 1 | Holding buffer can accept a byte |
| tx_done_o | output | 1 | No frame shifting and no byte pending |

## Verification
The assertions assume that the baud tick is a single-cycle pulse, and that `tx_en_i` is held low while reset is asserted. They also assume that writes are single-cycle strobes with the data valid in that cycle. The stimulus drives every input just after the falling clock edge and keeps ticks at one cycle in four. It holds the enable low through reset and the first cycles after it. Deliberate misuse, such as writing into a full buffer or while disabled, is issued as single strobes. A behavioural queue model then predicts what the outputs should show.

// File: rtl/sw_uart_tx_pkg.sv
package sw_uart_tx_pkg;
  localparam logic START_LVL = 1'b0;
  localparam logic STOP_LVL  = 1'b1;
  localparam logic IDLE_LVL  = 1'b1;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_IDLE,
    SRC_HOLD,
    SRC_WRITE
  } load_src_e;
endpackage

// File: rtl/sw_uart_tx_hold.sv
module sw_uart_tx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic              bypass_i,
  input  logic              take_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic accept;

  // slot is free if empty or being drained this cycle
  assign accept = wr_i && !bypass_i && (!valid_o || take_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end else if (accept) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (take_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sw_uart_tx_shift.sv
module sw_uart_tx_shift #(
  parameter int unsigned FRAME_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               tick_i,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               busy_o,
  output logic               free_o,
  output logic               line_o
);
  import sw_uart_tx_pkg::*;

  localparam int unsigned CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               ending;

  assign ending = busy_o && tick_i && (cnt_q == LAST);
  assign free_o = !busy_o || ending;
  assign line_o = busy_o ? sr_q[0] : IDLE_LVL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      sr_q   <= '1;
      cnt_q  <= '0;
    end else if (clr_i) begin
      busy_o <= 1'b0;
      sr_q   <= '1;
      cnt_q  <= '0;
    end else if (load_i) begin
      busy_o <= 1'b1;
      sr_q   <= frame_i;
      cnt_q  <= '0;
    end else if (ending) begin
      busy_o <= 1'b0;
      sr_q   <= '1;
      cnt_q  <= '0;
    end else if (busy_o && tick_i) begin
      sr_q   <= {IDLE_LVL, sr_q[FRAME_W-1:1]};
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/sw_uart_tx.sv
module sw_uart_tx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tx_en_i,
  input  logic              dir_tx_i,
  input  logic              pin_i,
  output logic              pin_o,
  output logic              pin_oe_o,
  output logic              rx_line_o,
  output logic              buf_empty_o,
  output logic              tx_done_o
);
  import sw_uart_tx_pkg::*;

  localparam int unsigned FRAME_W = DATA_W + 2;

  logic               en_q;
  logic               clr;
  load_src_e          src;
  logic [FRAME_W-1:0] frame;
  logic               hold_valid;
  logic [DATA_W-1:0]  hold_data;
  logic               sh_busy, sh_free, sh_line;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= tx_en_i;
  end

  assign clr = !tx_en_i;

  // priority: preamble on enable edge, then buffered byte, then direct write
  always_comb begin
    src = SRC_NONE;
    if (tx_en_i) begin
      if (!en_q)                     src = SRC_IDLE;
      else if (sh_free && hold_valid) src = SRC_HOLD;
      else if (sh_free && wr_en_i)    src = SRC_WRITE;
    end
  end

  always_comb begin
    unique case (src)
      SRC_HOLD:  frame = {STOP_LVL, hold_data, START_LVL};
      SRC_WRITE: frame = {STOP_LVL, wr_data_i, START_LVL};
      default:   frame = '1;
    endcase
  end

  sw_uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .wr_i     (wr_en_i && tx_en_i),
    .bypass_i (src == SRC_WRITE),
    .take_i   (src == SRC_HOLD),
    .data_i   (wr_data_i),
    .valid_o  (hold_valid),
    .data_o   (hold_data)
  );

  sw_uart_tx_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .tick_i  (baud_tick_i),
    .load_i  (src != SRC_NONE),
    .frame_i (frame),
    .busy_o  (sh_busy),
    .free_o  (sh_free),
    .line_o  (sh_line)
  );

  assign pin_o       = sh_line;
  assign pin_oe_o    = dir_tx_i;
  assign rx_line_o   = dir_tx_i ? sh_line : pin_i;
  assign buf_empty_o = !hold_valid;
  assign tx_done_o   = !sh_busy && !hold_valid;
endmodule

// File: rtl/sw_uart_tx_chk.sv
module sw_uart_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic baud_tick_i,
  input logic wr_en_i,
  input logic tx_en_i,
  input logic pin_o,
  input logic buf_empty_o,
  input logic tx_done_o
);
  // R8
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tx_en_i) |-> (pin_o && buf_empty_o && tx_done_o));

  // R2
  preamble_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_i) |=> (pin_o && !tx_done_o));

  // R6
  done_implies_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> buf_empty_o);

  // R4
  queued_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && tx_en_i && $past(tx_en_i) && !tx_done_o && !baud_tick_i) |=> !buf_empty_o);

  // R5
  direct_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && tx_en_i && $past(tx_en_i) && tx_done_o) |=> (!pin_o && buf_empty_o));

  // R9
  hold_between_ticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(tx_en_i) && $past(tx_en_i, 2) && !$past(baud_tick_i) && !$past(wr_en_i))
      |-> $stable(pin_o));
endmodule

bind sw_uart_tx sw_uart_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .baud_tick_i (baud_tick_i),
  .wr_en_i     (wr_en_i),
  .tx_en_i     (tx_en_i),
  .pin_o       (pin_o),
  .buf_empty_o (buf_empty_o),
  .tx_done_o   (tx_done_o)
);

// File: tb/sim_sw_uart_tx.sv
module sim_sw_uart_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wr = 1'b0, en = 1'b0, dir = 1'b1, pin_in = 1'b1;
  logic [7:0] wdata = '0;
  logic       pin, oe, rxl, bempty, done;

  always #5 clk = ~clk;

  sw_uart_tx #(.DATA_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick), .wr_en_i(wr),
    .wr_data_i(wdata), .tx_en_i(en), .dir_tx_i(dir), .pin_i(pin_in),
    .pin_o(pin), .pin_oe_o(oe), .rx_line_o(rxl),
    .buf_empty_o(bempty), .tx_done_o(done)
  );

  int checks = 0, fails = 0, cycles = 0;

  // behavioural model: queue of bits still to leave the wire
  bit       mq[$];
  bit       m_en_q = 1'b0, m_hv = 1'b0;
  bit [7:0] m_hd = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void push_frame(input bit [7:0] d);
    mq.push_back(1'b0);
    for (int i = 0; i < 8; i++) mq.push_back(d[i]);
    mq.push_back(1'b1);
  endfunction

  task automatic model_step();
    bit busy, free;
    if (!en) begin
      mq.delete();
      m_hv = 1'b0;
      m_en_q = 1'b0;
    end else begin
      busy = (mq.size() != 0);
      free = !busy || (tick && mq.size() == 1);
      if (busy && tick) void'(mq.pop_front());
      if (!m_en_q) begin
        for (int i = 0; i < 10; i++) mq.push_back(1'b1);
        if (wr) begin m_hv = 1'b1; m_hd = wdata; end
      end else if (free && m_hv) begin
        push_frame(m_hd);
        m_hv = 1'b0;
        if (wr) begin m_hv = 1'b1; m_hd = wdata; end
      end else if (free && wr) begin
        push_frame(wdata);
      end else if (wr && !m_hv) begin
        m_hv = 1'b1;
        m_hd = wdata;
      end
      m_en_q = 1'b1;
    end
  endtask

  task automatic compare();
    bit ep;
    ep = (mq.size() != 0) ? mq[0] : 1'b1;
    chk(pin == ep, "R3 model pin_o", pin, ep);
    chk(bempty == !m_hv, "R4 model buf_empty_o", bempty, !m_hv);
    chk(done == (mq.size() == 0 && !m_hv), "R6 model tx_done_o", done, (mq.size() == 0 && !m_hv));
    chk(oe == dir, "R1 model pin_oe_o", oe, dir);
    chk(rxl == (dir ? pin : pin_in), "R1 model rx_line_o", rxl, (dir ? pin : pin_in));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic tick_bit();
    tick = 1'b1; cyc(); tick = 1'b0;
    repeat (3) cyc();
  endtask

  task automatic write(input bit [7:0] d);
    wr = 1'b1; wdata = d; cyc(); wr = 1'b0;
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      summary();
      $finish;
    end
  end

  initial begin
    bit [7:0] got;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R8 reset / disabled state
    chk(pin == 1 && bempty == 1 && done == 1, "R8 reset idle", {pin, bempty, done}, 7);

    // R1 released wire
    dir = 1'b0; pin_in = 1'b0; cyc();
    chk(oe == 0, "R1 oe released", oe, 0);
    chk(rxl == 0, "R1 rx from pin_i", rxl, 0);
    pin_in = 1'b1; dir = 1'b1; cyc();

    // R2 preamble
    en = 1'b1; cyc();
    chk(pin == 1 && done == 0, "R2 preamble start", {pin, done}, 2);
    for (int k = 0; k < 10; k++) begin
      tick_bit();
      if (k < 9) chk(pin == 1 && done == 0, "R2 preamble shifting", {pin, done}, 2);
    end
    chk(done == 1, "R2 preamble end", done, 1);

    // R5 direct start, R3 frame format
    write(8'hA5);
    chk(pin == 0, "R5 start bit next cycle", pin, 0);
    chk(bempty == 1, "R5 buffer untouched", bempty, 1);
    for (int i = 0; i < 8; i++) begin tick_bit(); got[i] = pin; end
    chk(got == 8'hA5, "R3 data LSB first", got, 8'hA5);
    tick_bit();
    chk(pin == 1, "R3 stop bit", pin, 1);
    tick_bit();
    chk(done == 1 && pin == 1, "R3 frame end", {done, pin}, 3);

    // R9 no ticks, no change
    write(8'h3C);
    repeat (20) cyc();
    chk(pin == 0 && done == 0, "R9 held without tick", {pin, done}, 0);
    repeat (10) tick_bit();
    chk(done == 1, "R9 frame finished", done, 1);

    // R4 queue behind preamble, R7 drop on full buffer
    en = 1'b0; cyc(); en = 1'b1; cyc();
    write(8'h81);
    chk(bempty == 0, "R4 queued during preamble", bempty, 0);
    write(8'hFF);
    chk(bempty == 0, "R7 buffer still full", bempty, 0);
    repeat (9) tick_bit();
    chk(pin == 1 && bempty == 0, "R4 waiting for preamble", {pin, bempty}, 2);
    tick_bit();
    chk(pin == 0 && bempty == 1, "R4 start after preamble", {pin, bempty}, 1);
    for (int i = 0; i < 8; i++) begin tick_bit(); got[i] = pin; end
    chk(got == 8'h81, "R4 queued byte sent", got, 8'h81);
    repeat (2) tick_bit();
    chk(done == 1, "R7 second write not sent", done, 1);

    // R4 back-to-back frames, R1 while sending
    write(8'h12);
    write(8'h34);
    chk(bempty == 0, "R4 second byte held", bempty, 0);
    dir = 1'b0; pin_in = 1'b0; cyc();
    chk(oe == 0 && rxl == 0, "R1 released mid frame", {oe, rxl}, 0);
    dir = 1'b1; cyc();
    chk(rxl == pin, "R1 loop follows pin_o", rxl, pin);
    pin_in = 1'b1;
    repeat (10) tick_bit();
    chk(pin == 0 && bempty == 1, "R4 back-to-back start", {pin, bempty}, 1);
    for (int i = 0; i < 8; i++) begin tick_bit(); got[i] = pin; end
    chk(got == 8'h34, "R4 second byte data", got, 8'h34);
    repeat (2) tick_bit();
    chk(done == 1, "R6 all sent", done, 1);

    // R8 abort and ignored write
    write(8'h00);
    repeat (3) tick_bit();
    en = 1'b0; cyc();
    chk(pin == 1 && bempty == 1 && done == 1, "R8 abort", {pin, bempty, done}, 7);
    write(8'h55);
    chk(done == 1 && bempty == 1, "R8 write ignored", {done, bempty}, 3);
    repeat (2) tick_bit();
    chk(pin == 1, "R8 line idle", pin, 1);

    summary();
    $finish;
  end
endmodule